// File: doc/BRIEF.md
# Framed Register Command Responder

The responder takes in command frames made of one or more 16-bit words, offered one word per clock on a valid-qualified input stream. The last word of a frame is marked by an end-of-frame flag, and each word arrives with a flag saying whether its line parity was bad. Every word names a 5-bit register address and carries one data byte. A small register file holds four 8-bit analog setpoints and one 8-bit path/test control byte. In the control byte, bits 7..2 choose the direct path (1) or the attenuated path (0) at two attenuation steps for three channels, and bits 1..0 switch on two test signals. The register file drives these values straight to the converters outside the block.

Each time a frame ends, the block sends back a status reply of exactly 18 words on its output stream. The reply reports the serial number, the control byte, the setpoints and six sampled monitor bytes. Writes only take effect when the whole frame was received cleanly. If any word of the frame had a parity error, every write in that frame is thrown away, and bit 15 of every word in that frame's reply reports the error. A special command word asks the line coder to corrupt the parity of the reply on purpose, so the receiving side can test its parity checking. If frames end while a reply is still going out, their replies wait in a short queue and then follow back to back.

Top module: `cmd_frame_responder`

## Requirements
- R1: An input word is decoded as address = bits 12..8 and data = bits 7..0. Bits 14..13 are ignored. Bit 15 matters only in the command word described in R9.
- R2: Each accepted end-of-frame produces exactly one reply of 18 words, even when the frame has no defined address. When the block is idle, the first reply word is valid on the clock after the end-of-frame word is accepted. The 18 words are sent on consecutive clocks, and `out_valid` then drops unless another reply is queued.
- R3: Reply words have bits 14..13 = 0 and carry their address in bits 12..8. The address order is 0x01, 0x02, 0x11, 0x13, 0x14, 0x15, 0x16, 0x19, 0x1C, 0x1D, 0x1E, 0x1F, and then the filler addresses 0x03 to 0x08.
- R4: Reply data in bits 7..0 comes from these sources:
  - 0x01 gives `SERIAL_NUM`.
  - 0x02 gives the control byte.
  - 0x11, 0x13, 0x14 and 0x15 give setpoint bytes 0 to 3.
  - 0x16, 0x19, 0x1C, 0x1D, 0x1E and 0x1F give `mon_in` bytes 0 to 5, where byte j is bits 8j+7..8j.
  - The filler words give 0x00.
- R5: Bit 15 of every word of a reply is 1 exactly when a word of the frame that produced that reply was flagged with a parity error. A clean frame that follows gets a reply with bit 15 clear.
- R6: Writes to 0x02 and to 0x11, 0x13, 0x14 and 0x15 update `ctrl_out` and the matching `set_out` byte (byte i is bits 8i+7..8i) on the clock that accepts the end-of-frame word. When one address is written more than once in a frame, the last write wins.
- R7: If any word of a frame has a parity error, none of that frame's writes takes effect, including an R9 command.
- R8: Words that address an undefined location, a read-only monitor address, or 0x01 with bit 15 clear change no output other than by triggering the reply.
- R9: A word with address 0x01 and bit 15 set, in a clean frame, raises `out_par_bad` together with the first word of that frame's reply only.
- R10: After reset, `ctrl_out` and `set_out` are zero and `out_valid` and `out_par_bad` are low until the first end-of-frame.
- R11: Up to `REPLY_DEPTH` frames that end while a reply is being sent are queued. Their replies follow back to back, in frame order, each with its own error and forced-parity state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word valid |
| in_word | input | 16 | Command word |
| in_par_err | input | 1 | Parity error on this input word |
| in_eof | input | 1 | This word ends the frame |
| mon_in | input | 48 | Six sampled monitor bytes |
| ctrl_out | output | 8 | Path select and test enable byte |
| set_out | output | 32 | Four setpoint bytes |
| out_valid | output | 1 | Reply word valid |
| out_word | output | 16 | Reply word |
| out_par_bad | output | 1 | Line coder must send this word with wrong parity |

## Verification
A corrupted shadow copy or committed register shows up in `ctrl_out`/`set_out` on the clock after the end-of-frame. It also shows up in the data bytes of the very next reply. A stale error or force flag is visible in bit 15 or `out_par_bad` of the first reply word, one clock after the frame ends. A broken reply sequencer or queue shows up as a wrong address, a short or long reply, or a missing back-to-back reply within 36 clocks of the frames ending. The bench mixes directed frames with random frames, drawing addresses, flag bits, ignored bits and parity errors at random, and compares every reply word against a model of the registers.

// File: rtl/cfr_pkg.sv
package cfr_pkg;
  localparam int WORD_W    = 16;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 8;
  localparam int ADDR_LSB  = 8;
  localparam int FLAG_BIT  = 15;
  localparam int N_SET     = 4;
  localparam int N_MON     = 6;
  localparam int REPLY_LEN = 18;
  localparam logic [ADDR_W-1:0] ADDR_SERIAL = 5'h01;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 5'h02;

  typedef struct packed {
    logic err;
    logic force_pe;
  } reply_t;

  // setpoint slot -> register address
  function automatic logic [ADDR_W-1:0] set_addr(input int i);
    case (i)
      0:       return 5'h11;
      1:       return 5'h13;
      2:       return 5'h14;
      default: return 5'h15;
    endcase
  endfunction

  // monitor byte -> register address
  function automatic logic [ADDR_W-1:0] mon_addr(input int j);
    case (j)
      0:       return 5'h16;
      1:       return 5'h19;
      2:       return 5'h1C;
      3:       return 5'h1D;
      4:       return 5'h1E;
      default: return 5'h1F;
    endcase
  endfunction

  // reply word index -> address; tail of the reply is filler 0x03..0x08
  function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] k);
    case (k)
      5'd0:  return ADDR_SERIAL;
      5'd1:  return ADDR_CTRL;
      5'd2:  return set_addr(0);
      5'd3:  return set_addr(1);
      5'd4:  return set_addr(2);
      5'd5:  return set_addr(3);
      5'd6:  return mon_addr(0);
      5'd7:  return mon_addr(1);
      5'd8:  return mon_addr(2);
      5'd9:  return mon_addr(3);
      5'd10: return mon_addr(4);
      5'd11: return mon_addr(5);
      default: return k - 5'd9;
    endcase
  endfunction
endpackage

// File: rtl/cfr_regfile.sv
module cfr_regfile
  import cfr_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [WORD_W-1:0]       in_word,
  input  logic                    in_par_err,
  input  logic                    in_eof,
  output logic [DATA_W-1:0]       ctrl_q,
  output logic [N_SET*DATA_W-1:0] set_q,
  output logic                    done,
  output reply_t                  done_info
);
  logic [DATA_W-1:0] live_ctrl, sh_ctrl, nx_ctrl;
  logic [DATA_W-1:0] live_set [N_SET];
  logic [DATA_W-1:0] sh_set   [N_SET];
  logic [DATA_W-1:0] nx_set   [N_SET];
  logic              sh_err, nx_err, sh_force, nx_force;
  logic [ADDR_W-1:0] waddr;
  logic [DATA_W-1:0] wdata;

  assign waddr = in_word[ADDR_LSB +: ADDR_W];
  assign wdata = in_word[DATA_W-1:0];

  // frame-local shadow with the current word merged in
  always_comb begin
    nx_ctrl  = sh_ctrl;
    nx_set   = sh_set;
    nx_err   = sh_err;
    nx_force = sh_force;
    if (in_valid) begin
      nx_err = sh_err | in_par_err;
      if (waddr == ADDR_CTRL) nx_ctrl = wdata;
      if (waddr == ADDR_SERIAL && in_word[FLAG_BIT]) nx_force = 1'b1;
      for (int i = 0; i < N_SET; i++)
        if (waddr == set_addr(i)) nx_set[i] = wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_ctrl <= '0;
      sh_ctrl   <= '0;
      sh_err    <= 1'b0;
      sh_force  <= 1'b0;
      for (int i = 0; i < N_SET; i++) begin
        live_set[i] <= '0;
        sh_set[i]   <= '0;
      end
    end else if (in_valid) begin
      if (in_eof) begin
        sh_err   <= 1'b0;
        sh_force <= 1'b0;
        if (!nx_err) begin
          live_ctrl <= nx_ctrl;
          live_set  <= nx_set;
          sh_ctrl   <= nx_ctrl;
          sh_set    <= nx_set;
        end else begin
          sh_ctrl <= live_ctrl;
          sh_set  <= live_set;
        end
      end else begin
        sh_ctrl  <= nx_ctrl;
        sh_set   <= nx_set;
        sh_err   <= nx_err;
        sh_force <= nx_force;
      end
    end
  end

  assign done               = in_valid & in_eof;
  assign done_info.err      = nx_err;
  assign done_info.force_pe = nx_force & ~nx_err;
  assign ctrl_q             = live_ctrl;

  for (genvar g = 0; g < N_SET; g++) begin : g_flat
    assign set_q[g*DATA_W +: DATA_W] = live_set[g];
  end
endmodule

// File: rtl/cfr_reply_fifo.sv
module cfr_reply_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          full, do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
    end
  end

  assign dout = mem[rp];
endmodule

// File: rtl/cfr_status_tx.sv
module cfr_status_tx
  import cfr_pkg::*;
#(
  parameter logic [7:0] SERIAL_NUM = 8'h2A
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    q_empty,
  input  reply_t                  q_head,
  output logic                    q_pop,
  input  logic [DATA_W-1:0]       ctrl_q,
  input  logic [N_SET*DATA_W-1:0] set_q,
  input  logic [N_MON*DATA_W-1:0] mon_in,
  output logic                    out_valid,
  output logic [WORD_W-1:0]       out_word,
  output logic                    out_par_bad
);
  localparam int IW = ADDR_W;
  localparam logic [IW-1:0] LAST = IW'(REPLY_LEN - 1);

  logic [IW-1:0]     cur, nxt_idx;
  logic              err_l, cont, nxt_err;
  logic [ADDR_W-1:0] nxt_addr;
  logic [DATA_W-1:0] nxt_data;

  assign cont    = out_valid && (cur != LAST);
  assign q_pop   = !cont && !q_empty;
  assign nxt_idx = cont ? cur + 1'b1 : '0;
  assign nxt_err = cont ? err_l : q_head.err;
  assign nxt_addr = slot_addr(nxt_idx);

  always_comb begin
    nxt_data = '0;
    if (nxt_addr == ADDR_SERIAL) nxt_data = SERIAL_NUM;
    if (nxt_addr == ADDR_CTRL)   nxt_data = ctrl_q;
    for (int i = 0; i < N_SET; i++)
      if (nxt_addr == set_addr(i)) nxt_data = set_q[i*DATA_W +: DATA_W];
    for (int j = 0; j < N_MON; j++)
      if (nxt_addr == mon_addr(j)) nxt_data = mon_in[j*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_word    <= '0;
      out_par_bad <= 1'b0;
      cur         <= '0;
      err_l       <= 1'b0;
    end else if (cont || !q_empty) begin
      out_valid   <= 1'b1;
      cur         <= nxt_idx;
      err_l       <= nxt_err;
      out_word    <= {nxt_err, 2'b00, nxt_addr, nxt_data};
      out_par_bad <= cont ? 1'b0 : q_head.force_pe;
    end else begin
      out_valid   <= 1'b0;
      out_par_bad <= 1'b0;
    end
  end
endmodule

// File: rtl/cmd_frame_responder.sv
module cmd_frame_responder
  import cfr_pkg::*;
#(
  parameter logic [7:0] SERIAL_NUM  = 8'h2A,
  parameter int         REPLY_DEPTH = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [WORD_W-1:0]       in_word,
  input  logic                    in_par_err,
  input  logic                    in_eof,
  input  logic [N_MON*DATA_W-1:0] mon_in,
  output logic [DATA_W-1:0]       ctrl_out,
  output logic [N_SET*DATA_W-1:0] set_out,
  output logic                    out_valid,
  output logic [WORD_W-1:0]       out_word,
  output logic                    out_par_bad
);
  localparam int RW = $bits(reply_t);

  logic   done, q_empty, q_pop;
  reply_t done_info, q_head;
  logic [RW-1:0] q_dout;

  cfr_regfile u_regs (
    .clk, .rst, .in_valid, .in_word, .in_par_err, .in_eof,
    .ctrl_q(ctrl_out), .set_q(set_out), .done, .done_info
  );

  cfr_reply_fifo #(.DEPTH(REPLY_DEPTH), .W(RW)) u_queue (
    .clk, .rst, .push(done), .din(done_info), .pop(q_pop),
    .dout(q_dout), .empty(q_empty)
  );

  assign q_head = reply_t'(q_dout);

  cfr_status_tx #(.SERIAL_NUM(SERIAL_NUM)) u_tx (
    .clk, .rst, .q_empty, .q_head, .q_pop,
    .ctrl_q(ctrl_out), .set_q(set_out), .mon_in,
    .out_valid, .out_word, .out_par_bad
  );
endmodule

// File: rtl/cfr_checker.sv
module cfr_checker (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [7:0]  ctrl_out,
  input logic [31:0] set_out,
  input logic        out_valid,
  input logic [15:0] out_word,
  input logic        out_par_bad
);
  assert_reset_idle_R10: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_par_bad && ctrl_out == 8'h00 && set_out == 32'h0));

  assert_zero_bits_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_word[14:13] == 2'b00);

  assert_order_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid) && $past(out_word[12:8]) == 5'h01)
      |-> out_word[12:8] == 5'h02);

  assert_err_steady_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid) && out_word[12:8] != 5'h01)
      |-> out_word[15] == $past(out_word[15]));

  assert_pe_first_R9: assert property (@(posedge clk) disable iff (rst)
    out_par_bad |-> (out_valid && out_word[12:8] == 5'h01));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid) |-> ($stable(ctrl_out) && $stable(set_out)));
endmodule

bind cmd_frame_responder cfr_checker u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .ctrl_out(ctrl_out),
  .set_out(set_out), .out_valid(out_valid), .out_word(out_word),
  .out_par_bad(out_par_bad)
);

// File: tb/cmd_frame_responder_tb.sv
`timescale 1ns/1ps
module cmd_frame_responder_tb;
  localparam logic [7:0] SER = 8'h2A;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_par_err = 1'b0, in_eof = 1'b0;
  logic [15:0] in_word = '0;
  logic [47:0] mon_in = '0;
  logic [7:0]  ctrl_out;
  logic [31:0] set_out;
  logic        out_valid, out_par_bad;
  logic [15:0] out_word;

  always #4 clk = ~clk;

  cmd_frame_responder #(.SERIAL_NUM(SER), .REPLY_DEPTH(4)) u_dut (.*);

  int n_chk = 0, n_bad = 0;
  logic [7:0]  exp_ctrl;
  logic [7:0]  exp_set [4];
  logic [15:0] fw [16];
  logic        fp [16];
  int          fn;
  logic        f_err, f_frc;
  int          slot_tab [18] = '{'h01, 'h02, 'h11, 'h13, 'h14, 'h15, 'h16, 'h19,
                                 'h1C, 'h1D, 'h1E, 'h1F, 3, 4, 5, 6, 7, 8};
  int          pool [15] = '{'h01, 'h02, 'h11, 'h13, 'h14, 'h15, 'h16, 'h19,
                             'h1C, 'h1F, 'h03, 'h07, 'h0A, 'h1B, 'h00};

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int set_idx(input int a);
    case (a)
      'h11: return 0;
      'h13: return 1;
      'h14: return 2;
      'h15: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic logic [7:0] exp_data(input int a);
    case (a)
      'h01: return SER;
      'h02: return exp_ctrl;
      'h11, 'h13, 'h14, 'h15: return exp_set[set_idx(a)];
      'h16: return mon_in[7:0];
      'h19: return mon_in[15:8];
      'h1C: return mon_in[23:16];
      'h1D: return mon_in[31:24];
      'h1E: return mon_in[39:32];
      'h1F: return mon_in[47:40];
      default: return 8'h00;
    endcase
  endfunction

  // drive the frame in fw/fp/fn and update the model (R1, R6, R7, R9)
  task automatic drive_frame();
    logic [7:0] sc, ss [4];
    logic e, f;
    sc = exp_ctrl; ss = exp_set; e = 0; f = 0;
    for (int i = 0; i < fn; i++) begin
      int a;
      @(negedge clk);
      in_valid = 1; in_word = fw[i]; in_par_err = fp[i]; in_eof = (i == fn - 1);
      a = int'(fw[i][12:8]);
      e |= fp[i];
      if (a == 'h02) sc = fw[i][7:0];
      if (set_idx(a) >= 0) ss[set_idx(a)] = fw[i][7:0];
      if (a == 'h01 && fw[i][15]) f = 1;
    end
    f_err = e;
    f_frc = f & ~e;
    if (!e) begin exp_ctrl = sc; exp_set = ss; end
  endtask

  task automatic idle_in();
    in_valid = 0; in_eof = 0; in_par_err = 0; in_word = '0;
  endtask

  task automatic check_reply(input logic e, input logic frc, input bit now);
    for (int k = 0; k < 18; k++) begin
      if (!(now && k == 0)) @(negedge clk);
      chk("R2", $sformatf("valid w%0d", k), 32'(out_valid), 1);
      chk("R3", $sformatf("addr w%0d", k), 32'(out_word[14:8]), 32'(slot_tab[k]));
      chk("R4", $sformatf("data w%0d", k), 32'(out_word[7:0]), 32'(exp_data(slot_tab[k])));
      chk("R5", $sformatf("err w%0d", k), 32'(out_word[15]), 32'(e));
      chk("R9", $sformatf("par_bad w%0d", k), 32'(out_par_bad), 32'(frc && k == 0));
    end
  endtask

  task automatic check_end(input string req);
    @(negedge clk);
    chk("R2", "valid after reply", 32'(out_valid), 0);
    chk(req, "ctrl_out", 32'(ctrl_out), 32'(exp_ctrl));
    chk(req, "set_out", set_out, {exp_set[3], exp_set[2], exp_set[1], exp_set[0]});
  endtask

  task automatic run_frame(input string req);
    mon_in = {16'($urandom), 32'($urandom)};
    drive_frame();
    @(negedge clk);
    idle_in();
    check_reply(f_err, f_frc, 0);
    check_end(req);
  endtask

  function automatic logic [15:0] mk(input int a, input logic [7:0] d, input logic flag);
    return {flag, 2'b00, 5'(a), d};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic e1, c1;
    void'($urandom(32'd20250611));
    exp_ctrl = 0;
    for (int i = 0; i < 4; i++) exp_set[i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk("R10", "out_valid idle", 32'(out_valid), 0);
    chk("R10", "out_par_bad idle", 32'(out_par_bad), 0);
    chk("R10", "ctrl_out reset", 32'(ctrl_out), 0);
    chk("R10", "set_out reset", set_out, 0);

    // R6: writes to every writable location, repeated address: last wins
    fn = 6;
    fw[0] = mk('h02, 8'h11, 0); fw[1] = mk('h11, 8'h12, 0); fw[2] = mk('h13, 8'h34, 0);
    fw[3] = mk('h14, 8'h56, 0); fw[4] = mk('h15, 8'h78, 0); fw[5] = mk('h02, 8'hA5, 0);
    for (int i = 0; i < 16; i++) fp[i] = 0;
    run_frame("R6");
    chk("R6", "last write wins", 32'(ctrl_out), 32'hA5);

    // R8: undefined, read-only, serial without flag; R1 ignores bits 14..13
    fn = 4;
    fw[0] = mk('h16, 8'hFF, 0); fw[1] = mk('h03, 8'h99, 0);
    fw[2] = mk('h01, 8'h77, 0); fw[3] = mk('h1F, 8'h01, 1);
    run_frame("R8");
    fn = 1; fw[0] = mk('h11, 8'hC3, 0) | 16'h6000;
    run_frame("R1");
    chk("R1", "bits 14..13 ignored", 32'(set_out[7:0]), 32'hC3);

    // R7/R5: parity error on a late word discards the whole frame
    fn = 3;
    fw[0] = mk('h02, 8'h3C, 0); fw[1] = mk('h01, 8'h00, 1); fw[2] = mk('h15, 8'hEE, 0);
    fp[2] = 1;
    run_frame("R7");
    chk("R7", "ctrl kept", 32'(ctrl_out), 32'hA5);
    fp[2] = 0;
    fn = 1; fw[0] = mk('h0A, 8'h00, 0);
    run_frame("R5");   // clean frame, bit 15 clear again

    // R9: forced parity, then one-shot
    fn = 1; fw[0] = mk('h01, 8'h00, 1);
    run_frame("R9");
    fn = 1; fw[0] = mk('h03, 8'h00, 0);
    run_frame("R9");

    // R11: two frames back to back; first with parity error, second forces parity
    fn = 1; fw[0] = mk('h07, 8'h00, 0); fp[0] = 1;
    drive_frame();
    e1 = f_err; c1 = f_frc;
    fp[0] = 0; fw[0] = mk('h01, 8'h55, 1);
    drive_frame();
    @(negedge clk);
    idle_in();
    check_reply(e1, c1, 1);
    chk("R11", "first queued err", 32'(e1), 1);
    check_reply(f_err, f_frc, 0);
    check_end("R11");

    // random frames
    for (int t = 0; t < 60; t++) begin
      fn = 1 + int'($urandom % 6);
      for (int i = 0; i < fn; i++) begin
        fw[i] = {1'($urandom % 4 == 0), 2'($urandom), 5'(pool[$urandom % 15]), 8'($urandom)};
        fp[i] = ($urandom % 10 == 0);
      end
      run_frame("R1");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule